// File: doc/BRIEF.md
# Banked Byte-Write Synchronous SRAM

This block is a synthesizable behavioural model of a flow-through synchronous SRAM. Its storage is split into four banks that can be enabled one at a time. Each word is 64 data bits plus 8 parity bits, arranged as eight byte lanes. Address, bank enables and write controls are sampled on the rising clock edge. Write data is taken on that same edge, so every write is an early write. Read data comes straight from the array for the address that is currently registered, with no output register in between. An asynchronous output enable gates the read data onto the output bus.

A cycle starts on one of two strobes. The read-start strobe always begins a read. The read/write-start strobe begins a read or a write, depending on the write controls. While neither strobe is low, a step input moves the internal address through a 4-beat burst, in either linear or interleaved order, and writes that arrive during a burst land on the stepped address. A write-all input writes every lane. Otherwise, each lane is written only when the byte-write enable and that lane's strobe are both low. Each bank has a sleep input. A sleeping bank ignores accesses and drives nothing, and it keeps its contents.

The tristate data bus is modelled with separate outputs. `bus_drive_o` shows when the block would drive the bus. While it is low, the read data and parity outputs are held at zero.

Top module: `bsram_core`

## Requirements
- R1: While rst_ni is low, and after reset until the first access, bus_drive_o is 0.
- R2: Lane n holds data bits 8n+7..8n together with parity bit n. Lane strobe bit n writes both of them and touches no other lane.
- R3: When wr_all_ni is 0 on a write edge, all 72 bits are written, whatever byte_wr_ni and lane_wr_ni are.
- R4: When wr_all_ni is 1, lane n is written only if byte_wr_ni is 0 and lane_wr_ni[n] is 0. With byte_wr_ni at 1, nothing is written.
- R5: At a cycle start, the bank chosen is the lowest-numbered bank whose enable bank_sel_ni[i] is 0 and whose sleep_i[i] is 0. If start_rw_ni is 0 and no bank qualifies, the block is deselected and drives nothing.
- R6: start_rd_ni at 0 with a qualifying bank starts a read at addr_i and performs no write, even if start_rw_ni and the write controls are also low. With no qualifying bank, start_rd_ni is ignored.
- R7: start_rw_ni at 0 (with start_rd_ni at 1 or no bank) starts a cycle at addr_i. If any lane would be written under R3/R4, the cycle is a write, taken on that same edge. Otherwise it is a read.
- R8: While both strobes are 1 and a cycle is active, step_ni at 0 advances a 2-bit beat count k, and step_ni at 1 holds it. The address is {start[AW-1:2], start[1:0]+k mod 4} when burst_linear_i is 1, and {start[AW-1:2], start[1:0] xor k} when it is 0. Writes in these cycles go to the new address.
- R9: Read data for the registered address appears combinationally after the edge that registers it: the first datum in the cycle after the address is presented, then one beat per cycle.
- R10: bus_drive_o is 1 only while out_en_ni is 0, a cycle is active, and that cycle is a read. This responds without a clock edge. While bus_drive_o is 0, rdata_o and rpar_o are 0.
- R11: While sleep_i[b] is 1, bank b takes no writes and drives no data. Its contents are unchanged when it wakes.
- R12: A read of a location written on the previous edge returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address within a bank |
| bank_sel_ni | input | NB | Per-bank enables, active low |
| sleep_i | input | NB | Per-bank sleep, active high |
| start_rd_ni | input | 1 | Read-start strobe, active low |
| start_rw_ni | input | 1 | Read/write-start strobe, active low |
| step_ni | input | 1 | Burst advance, active low |
| burst_linear_i | input | 1 | 1 selects linear order, 0 interleaved |
| wr_all_ni | input | 1 | Write all lanes, active low |
| byte_wr_ni | input | 1 | Byte-write enable, active low |
| lane_wr_ni | input | NBYTE | Per-lane write strobes, active low |
| wdata_i | input | NBYTE*8 | Write data |
| wpar_i | input | NBYTE | Write parity |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | NBYTE*8 | Read data |
| rpar_o | output | NBYTE | Read parity |
| bus_drive_o | output | 1 | Bus is being driven |

## Verification
Two functions can fall in the same cycle, and the checks aim at those collisions:
- Both start strobes can be low together while the write controls ask for a write. The bench provokes this at a known address and then reads the location back; it must hold its old contents.
- A burst write can be in progress on a bank whose sleep input rises mid-burst. The bench provokes this and then wakes the bank; a burst read must return the data written before sleep, beat for beat.

A behavioural reference model runs alongside the design and is compared on every clock. Extra probes toggle the output enable between edges to confirm the asynchronous gating.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANE_W = 8;

  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_ADD = 1'b1
  } burst_ord_e;

  // low two address bits for beat k of a burst starting at 'start'
  function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                          input logic [1:0] k,
                                          input burst_ord_e ord);
    return (ord == ORD_ADD) ? 2'(start + k) : (start ^ k);
  endfunction
endpackage

// File: rtl/bsram_seq.sv
module bsram_seq
  import bsram_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          step_i,
  input  logic          linear_i,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] tgt_addr_o
);
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  burst_ord_e    ord;

  assign ord    = linear_i ? ORD_ADD : ORD_XOR;
  assign base_d = load_i ? load_addr_i : base_q;
  assign cnt_d  = load_i ? 2'd0 : (step_i ? 2'(cnt_q + 2'd1) : cnt_q);

  // address the coming edge will act on, and address registered now
  assign tgt_addr_o = {base_d[AW-1:2], beat_lsb(base_d[1:0], cnt_d, ord)};
  assign cur_addr_o = {base_q[AW-1:2], beat_lsb(base_q[1:0], cnt_q, ord)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl #(
  parameter int NB    = 4,
  parameter int NBYTE = 8,
  localparam int BIW  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NB-1:0]    bank_sel_ni,
  input  logic [NB-1:0]    sleep_i,
  input  logic             start_rd_ni,
  input  logic             start_rw_ni,
  input  logic             step_ni,
  input  logic             wr_all_ni,
  input  logic             byte_wr_ni,
  input  logic [NBYTE-1:0] lane_wr_ni,
  output logic             load_o,
  output logic             step_o,
  output logic             we_o,
  output logic [BIW-1:0]   wbank_o,
  output logic [NBYTE-1:0] wmask_o,
  output logic             act_o,
  output logic             rd_cyc_o,
  output logic [BIW-1:0]   bank_o
);
  logic [NB-1:0]  elig;
  logic           any_bank;
  logic [BIW-1:0] pick;
  logic           act_q, act_d, wr_q, wr_d;
  logic [BIW-1:0] bank_q, bank_d;
  logic           wreq, go_rd;

  assign elig = ~bank_sel_ni & ~sleep_i;

  // lowest-numbered eligible bank wins
  always_comb begin
    pick     = '0;
    any_bank = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (elig[i] && !any_bank) begin
        pick     = BIW'(i);
        any_bank = 1'b1;
      end
    end
  end

  assign wmask_o = !wr_all_ni ? '1 : (!byte_wr_ni ? ~lane_wr_ni : '0);
  assign wreq    = |wmask_o;
  assign go_rd   = !start_rd_ni && any_bank;

  always_comb begin
    act_d  = act_q;
    bank_d = bank_q;
    wr_d   = wr_q;
    load_o = 1'b0;
    step_o = 1'b0;
    if (go_rd) begin
      act_d  = 1'b1;
      bank_d = pick;
      wr_d   = 1'b0;
      load_o = 1'b1;
    end else if (!start_rw_ni) begin
      if (any_bank) begin
        act_d  = 1'b1;
        bank_d = pick;
        wr_d   = wreq;
        load_o = 1'b1;
      end else begin
        act_d = 1'b0;
        wr_d  = 1'b0;
      end
    end else if (act_q) begin
      step_o = !step_ni;
      wr_d   = wreq;
    end
  end

  assign we_o     = act_d && wr_d && !sleep_i[bank_d];
  assign wbank_o  = bank_d;
  assign act_o    = act_q;
  assign rd_cyc_o = act_q && !wr_q;
  assign bank_o   = bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      bank_q <= '0;
    end else begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      bank_q <= bank_d;
    end
  end
endmodule

// File: rtl/bsram_bank.sv
module bsram_bank
  import bsram_pkg::*;
#(
  parameter int AW    = 5,
  parameter int NBYTE = 8,
  localparam int DEPTH = 1 << AW,
  localparam int DW    = NBYTE * LANE_W
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [NBYTE-1:0] wmask_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NBYTE-1:0] wpar_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o,
  output logic [NBYTE-1:0] rpar_o
);
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    logic [LANE_W:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[b])
        lane_mem[waddr_i] <= {wpar_i[b], wdata_i[b*LANE_W +: LANE_W]};
    end

    assign rdata_o[b*LANE_W +: LANE_W] = lane_mem[raddr_i][LANE_W-1:0];
    assign rpar_o[b]                   = lane_mem[raddr_i][LANE_W];
  end
endmodule

// File: rtl/bsram_core.sv
module bsram_core
  import bsram_pkg::*;
#(
  parameter int NB    = 4,
  parameter int NBYTE = 8,
  parameter int AW    = 5,
  localparam int DW   = NBYTE * LANE_W,
  localparam int BIW  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [NB-1:0]    bank_sel_ni,
  input  logic [NB-1:0]    sleep_i,
  input  logic             start_rd_ni,
  input  logic             start_rw_ni,
  input  logic             step_ni,
  input  logic             burst_linear_i,
  input  logic             wr_all_ni,
  input  logic             byte_wr_ni,
  input  logic [NBYTE-1:0] lane_wr_ni,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NBYTE-1:0] wpar_i,
  input  logic             out_en_ni,
  output logic [DW-1:0]    rdata_o,
  output logic [NBYTE-1:0] rpar_o,
  output logic             bus_drive_o
);
  logic             load, step, we, act, rd_cyc;
  logic [BIW-1:0]   wbank, bank;
  logic [NBYTE-1:0] wmask;
  logic [AW-1:0]    cur_addr, tgt_addr;
  logic [DW-1:0]    bank_rd   [NB];
  logic [NBYTE-1:0] bank_rpar [NB];
  logic             drive;

  bsram_ctrl #(.NB(NB), .NBYTE(NBYTE)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bank_sel_ni (bank_sel_ni),
    .sleep_i     (sleep_i),
    .start_rd_ni (start_rd_ni),
    .start_rw_ni (start_rw_ni),
    .step_ni     (step_ni),
    .wr_all_ni   (wr_all_ni),
    .byte_wr_ni  (byte_wr_ni),
    .lane_wr_ni  (lane_wr_ni),
    .load_o      (load),
    .step_o      (step),
    .we_o        (we),
    .wbank_o     (wbank),
    .wmask_o     (wmask),
    .act_o       (act),
    .rd_cyc_o    (rd_cyc),
    .bank_o      (bank)
  );

  bsram_seq #(.AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_addr_i (addr_i),
    .step_i      (step),
    .linear_i    (burst_linear_i),
    .cur_addr_o  (cur_addr),
    .tgt_addr_o  (tgt_addr)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic bank_we;
    assign bank_we = we && (wbank == BIW'(g));

    bsram_bank #(.AW(AW), .NBYTE(NBYTE)) u_bank (
      .clk_i   (clk_i),
      .we_i    (bank_we),
      .wmask_i (wmask),
      .waddr_i (tgt_addr),
      .wdata_i (wdata_i),
      .wpar_i  (wpar_i),
      .raddr_i (cur_addr),
      .rdata_o (bank_rd[g]),
      .rpar_o  (bank_rpar[g])
    );
  end

  // flow-through: array output gated straight to the pins
  assign drive       = act && rd_cyc && !out_en_ni && !sleep_i[bank];
  assign bus_drive_o = drive;
  assign rdata_o     = drive ? bank_rd[bank] : '0;
  assign rpar_o      = drive ? bank_rpar[bank] : '0;
endmodule

// File: rtl/bsram_core_chk.sv
module bsram_core_chk #(
  parameter int NB    = 4,
  parameter int NBYTE = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NB-1:0]      bank_sel_ni,
  input logic [NB-1:0]      sleep_i,
  input logic               start_rd_ni,
  input logic               start_rw_ni,
  input logic               wr_all_ni,
  input logic               out_en_ni,
  input logic [NBYTE*8-1:0] rdata_o,
  input logic [NBYTE-1:0]   rpar_o,
  input logic               bus_drive_o
);
  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> !bus_drive_o);

  a_r10_oe_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_ni |-> !bus_drive_o);

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_drive_o |-> (rdata_o == '0 && rpar_o == '0));

  a_r11_all_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&sleep_i) |-> !bus_drive_o);

  a_r5_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_rw_ni && start_rd_ni && (&bank_sel_ni)) |=> !bus_drive_o);

  a_r7_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_rd_ni && !start_rw_ni && !wr_all_ni && (|(~bank_sel_ni & ~sleep_i)))
    |=> !bus_drive_o);

  a_r6_rd_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_rd_ni && (|(~bank_sel_ni & ~sleep_i)))
    |=> (bus_drive_o || out_en_ni || (|sleep_i)));
endmodule

bind bsram_core bsram_core_chk #(.NB(NB), .NBYTE(NBYTE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bank_sel_ni (bank_sel_ni),
  .sleep_i     (sleep_i),
  .start_rd_ni (start_rd_ni),
  .start_rw_ni (start_rw_ni),
  .wr_all_ni   (wr_all_ni),
  .out_en_ni   (out_en_ni),
  .rdata_o     (rdata_o),
  .rpar_o      (rpar_o),
  .bus_drive_o (bus_drive_o)
);

// File: tb/bsram_core_test.sv
`timescale 1ns/1ps
module bsram_core_test;
  localparam int NB = 4;
  localparam int NBYTE = 8;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] r_addr = '0;
  logic [NB-1:0] r_bsel = '1, r_sleep = '0;
  logic r_srd = 1'b1, r_srw = 1'b1, r_step = 1'b1, r_lin = 1'b1;
  logic r_wall = 1'b1, r_bwr = 1'b1, r_oe = 1'b0;
  logic [NBYTE-1:0] r_lane = '1, r_wp = '0;
  logic [63:0] r_wd = '0;
  logic [63:0] rdata;
  logic [7:0] rpar;
  logic drive;

  int checks = 0, failures = 0;

  // reference model state
  logic [63:0] md [NB][DEPTH];
  logic [7:0]  mp [NB][DEPTH];
  bit m_act = 0, m_wr = 0;
  int m_bank = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_cnt = '0;

  always #4 clk = ~clk;

  bsram_core #(.NB(NB), .NBYTE(NBYTE), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(r_addr), .bank_sel_ni(r_bsel),
    .sleep_i(r_sleep), .start_rd_ni(r_srd), .start_rw_ni(r_srw),
    .step_ni(r_step), .burst_linear_i(r_lin), .wr_all_ni(r_wall),
    .byte_wr_ni(r_bwr), .lane_wr_ni(r_lane), .wdata_i(r_wd), .wpar_i(r_wp),
    .out_en_ni(r_oe), .rdata_o(rdata), .rpar_o(rpar), .bus_drive_o(drive)
  );

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = r_lin ? 2'(m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic m_write(input int b, input logic [AW-1:0] a, input logic [7:0] mask);
    for (int n = 0; n < NBYTE; n++)
      if (mask[n]) begin
        md[b][a][8*n +: 8] = r_wd[8*n +: 8];
        mp[b][a][n] = r_wp[n];
      end
  endtask

  task automatic model_edge();
    int sel;
    logic [7:0] mask;
    sel = -1;
    for (int i = NB - 1; i >= 0; i--)
      if (!r_bsel[i] && !r_sleep[i]) sel = i;
    mask = !r_wall ? 8'hFF : (!r_bwr ? ~r_lane : 8'h00);
    if (!r_srd && sel >= 0) begin
      m_act = 1; m_bank = sel; m_base = r_addr; m_cnt = 0; m_wr = 0;
    end else if (!r_srw) begin
      if (sel >= 0) begin
        m_act = 1; m_bank = sel; m_base = r_addr; m_cnt = 0; m_wr = (mask != 0);
        if (m_wr) m_write(m_bank, r_addr, mask);
      end else begin
        m_act = 0; m_wr = 0;
      end
    end else if (m_act) begin
      if (!r_step) m_cnt = 2'(m_cnt + 2'd1);
      m_wr = (mask != 0);
      if (m_wr && !r_sleep[m_bank]) m_write(m_bank, m_addr(), mask);
    end
  endtask

  task automatic compare(input string tag);
    bit ed;
    logic [63:0] xd;
    logic [7:0] xp;
    ed = m_act && !m_wr && !r_oe && !r_sleep[m_bank];
    xd = ed ? md[m_bank][m_addr()] : 64'h0;
    xp = ed ? mp[m_bank][m_addr()] : 8'h0;
    checks++;
    if (drive !== ed || rdata !== xd || rpar !== xp) begin
      failures++;
      $display("FAIL %s: drive=%0b data=%h par=%h expected drive=%0b data=%h par=%h",
               tag, drive, rdata, rpar, ed, xd, xp);
    end
  endtask

  // inputs are set at the falling edge; compare shortly after the rising edge
  task automatic step(input string tag, input bit probe);
    @(posedge clk);
    model_edge();
    #2 compare(tag);
    if (probe) begin
      #0.5 r_oe = 1'b1;
      #0.5 compare({tag, " R10 oe high"});
      r_oe = 1'b0;
      #0.5 compare({tag, " R10 oe low"});
    end
    @(negedge clk);
  endtask

  task automatic idle();
    r_srd = 1; r_srw = 1; r_step = 1; r_wall = 1; r_bwr = 1; r_lane = '1; r_bsel = '1;
  endtask

  task automatic start(input int b, input int a);
    idle();
    r_srw = 0; r_bsel = ~(NB'(1) << b); r_addr = AW'(a);
  endtask

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    @(negedge clk);
    compare("R1 in reset");
    @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;

    // preload every location with a known pattern
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < DEPTH; a++) begin
        start(b, a); r_wall = 0;
        r_wd = {32'(b * 1000 + a), 32'hA5A5_0000 ^ 32'(a)};
        r_wp = 8'(a * 7 + b);
        step("R7 preload write, not driven", 0);
      end

    start(0, 3); step("R9 flow-through read", 1);
    start(1, 17); step("R7 read start", 1);

    start(0, 4); r_wall = 0; r_wd = 64'h1122_3344_5566_7788; r_wp = 8'h3C;
    step("R12 write", 0);
    start(0, 4); step("R12 read after write", 1);

    start(2, 6); r_bwr = 0; r_lane = 8'b0101_1010; r_wd = 64'hFFEE_DDCC_BBAA_9988; r_wp = 8'hFF;
    step("R2 lane write", 0);
    start(2, 6); step("R2 lane readback", 0);

    start(2, 6); r_bwr = 1; r_lane = 8'h00; r_wd = 64'h0; r_wp = 8'h00;
    step("R4 byte enable high", 0);
    start(2, 6); step("R4 no write readback", 0);

    start(3, 7); r_wall = 0; r_bwr = 1; r_lane = 8'hFF; r_wd = 64'hCAFE_F00D_1234_5678; r_wp = 8'h81;
    step("R3 write-all override", 0);
    start(3, 7); step("R3 readback", 0);
    start(3, 8); r_wall = 0; r_bwr = 0; r_lane = 8'hF0; r_wd = 64'h0BAD_0BAD_0BAD_0BAD; r_wp = 8'h5A;
    step("R3 override lane mask", 0);
    start(3, 8); step("R3 all lanes written", 0);

    start(2, 10); r_srd = 0; r_wall = 0; r_wd = 64'hDEAD_BEEF_DEAD_BEEF; r_wp = 8'h11;
    step("R6 both strobes, read wins", 1);
    idle(); step("R6 held read, no write", 0);
    idle(); r_srd = 0; step("R6 read strobe without bank ignored", 0);

    idle(); r_srw = 0; step("R5 deselect", 0);
    start(1, 12); r_bsel = 4'b1001; step("R5 lowest bank chosen", 0);

    r_lin = 1; start(0, 5); step("R8 linear start", 0);
    for (int k = 0; k < 4; k++) begin
      idle(); r_step = 0; step("R8 linear beat", 0);
    end
    idle(); step("R8 suspend", 0);
    r_lin = 0; start(1, 7); step("R8 interleaved start", 0);
    for (int k = 0; k < 3; k++) begin
      idle(); r_step = 0; step("R8 interleaved beat", 0);
    end
    r_lin = 1; start(3, 14); r_wall = 0; r_wd = 64'h1; r_wp = 8'h1;
    step("R8 burst write start", 0);
    for (int k = 0; k < 3; k++) begin
      idle(); r_step = 0; r_wall = 0; r_wd = 64'(k + 2) << 8; r_wp = 8'(k + 2);
      step("R8 burst write beat", 0);
    end
    start(3, 14); step("R8 burst readback", 0);
    for (int k = 0; k < 3; k++) begin
      idle(); r_step = 0; step("R8 burst readback beat", 0);
    end

    r_oe = 1; start(1, 20); step("R10 read with oe high", 0); r_oe = 0;
    idle(); step("R10 oe low again", 0);

    r_sleep = 4'b0100; start(2, 2); r_wall = 0; r_wd = 64'h0; r_wp = 8'h0;
    step("R11 asleep bank start ignored", 0);
    r_sleep = 4'b0000; start(2, 2); step("R11 contents kept", 0);
    start(2, 20); step("R11 read before sleep", 0);
    r_sleep = 4'b0100;
    for (int k = 0; k < 3; k++) begin
      idle(); r_step = 0; r_wall = 0; r_wd = 64'hFFFF; r_wp = 8'hFF;
      step("R11 sleep mid-burst write", 0);
    end
    r_sleep = 4'b0000; start(2, 20); step("R11 wake readback", 0);
    for (int k = 0; k < 3; k++) begin
      idle(); r_step = 0; step("R11 wake readback beat", 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule